// File: doc/BRIEF.md
# Four-Channel Hit Timestamp Controller

This block assigns a time stamp to each hit on four measuring channels. The time of a hit is built from three fields. The coarse field counts 16 ns periods since the last collision-locked sync marker. The phase field gives the 1 ns position within that period, taken from the PLL feedback divider. The fine field counts fast-clock cycles while the gate from the analog time stretcher is open. The stretcher makes its gate 200 times wider than the interval it measures, so the fine count, scaled back by 200, gives the sub-nanosecond part. The result tells when the hit happened relative to the sync pulse.

Everything runs on the fast count clock. The sync marker and the four gates arrive asynchronously, and each passes through a two-stage synchronizer. The divider phase arrives as a bus that is stable at each clock edge. The coarse counter advances when the phase wraps from all-ones to zero. When a gate opens, its channel latches the coarse value and the phase. While the gate stays open the channel counts cycles, and it saturates at all-ones. When the gate closes, the channel presents its word with a valid flag. The channel holds that word until downstream logic accepts it through a valid/ready handshake. Until then it does not take another hit.

Top module: `hit_stamp_ctrl`

## Requirements
- R1: After reset every valid output is low and the coarse counter is zero, so the first hit after reset carries a coarse field of 0.
- R2: The coarse counter increases by one on each clock where the phase input reads 0 and read all-ones on the clock before. It wraps modulo 2^COARSE_W, so 32 wraps return it to 0 with the default width.
- R3: A rising edge on the synchronized sync marker clears the coarse counter to 0. When a sync edge and a phase wrap fall on the same clock, the clear wins.
- R4: When a channel's synchronized gate rises, the channel captures the current coarse count and the current phase input. The capture happens SYNC_STAGES+1 clock edges after the first edge that samples the gate input high.
- R5: The fine field equals the number of rising clock edges at which the gate input was sampled high.
- R6: The fine field saturates at all-ones (2^FINE_W-1) when the gate stays open for longer than that many cycles.
- R7: Word layout, from most significant bit down: channel index (CH_W bits, channel n carries n), coarse (COARSE_W bits), phase (PHASE_W bits), and fine (FINE_W bits) in the least significant bits.
- R8: With two synchronizer stages, valid rises on the third rising edge after the first edge that samples the gate input low, and not on the second. It then stays high with the word unchanged for as long as ready is low.
- R9: A clock edge with valid and ready both high drops valid. Gate pulses that arrive while valid is high leave the word unchanged and produce no word after the accept.
- R10: A sync edge during an open gate does not change the coarse value that the channel captured for that hit.
- R11: The channels run independently. Simultaneous hits on different channels each produce their own word and valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast count clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_i | input | PHASE_W | Current count of the PLL feedback divider (1 ns phase) |
| sync_i | input | 1 | Asynchronous collision-locked sync marker |
| gate_i | input | N_CH | Asynchronous stretched gates, one per channel |
| ready_i | input | N_CH | Per-channel accept from downstream |
| valid_o | output | N_CH | Per-channel word available |
| stamp_o | output | N_CH*WORD_W | Per-channel timestamp words, channel n at bits [n*WORD_W +: WORD_W] |

## Verification
The bench builds the block with FINE_W = 8 and keeps the other defaults: four channels, a 5-bit coarse field, a 4-bit phase and two synchronizer stages. The narrow fine counter lets a gate of about 300 cycles reach saturation, while a full 32-wrap coarse cycle stays cheap. With this build the bench can also place a sync edge and a phase wrap on the same clock edge, check the exact cycle on which valid rises, and open gates on two channels at once.

// File: rtl/ts_pkg.sv
// Package ts_pkg
// Shared types for the hit timestamp controller.
// Assumes: consumers import it; holds no parameters that depend on the instance.
package ts_pkg;
    // Life cycle of one measuring channel
    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_OPEN = 2'd1,
        CH_HOLD = 2'd2
    } ch_state_t;
endpackage

// File: rtl/ts_sync.sv
// Module ts_sync
// Multi-stage synchronizer that brings one asynchronous level into the clk domain.
// Assumes: STAGES >= 2; the input pulse is wider than one clock period.
module ts_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ts_coarse.sv
// Module ts_coarse
// Counts 16 ns periods by watching the divider phase wrap, and clears on a sync edge.
// Assumes: sync_lvl_i is already synchronized and phase_i is stable at each clock edge.
module ts_coarse #(
    parameter int COARSE_W = 5,
    parameter int PHASE_W  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sync_lvl_i,
    input  logic [PHASE_W-1:0]  phase_i,
    output logic [COARSE_W-1:0] coarse_o
);
    localparam logic [PHASE_W-1:0] PHASE_TOP = '1;

    logic               sync_q;
    logic [PHASE_W-1:0] phase_q;
    logic               sync_rise;
    logic               wrap;

    assign sync_rise = sync_lvl_i & ~sync_q;
    assign wrap      = (phase_q == PHASE_TOP) && (phase_i == '0);

    // Keep the previous sync level and phase for edge and wrap detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= 1'b0;
            phase_q <= '0;
        end else begin
            sync_q  <= sync_lvl_i;
            phase_q <= phase_i;
        end
    end

    // The coarse counter: the sync clear wins over the increment
    always_ff @(posedge clk) begin
        if (!rst_n)         coarse_o <= '0;
        else if (sync_rise) coarse_o <= '0;
        else if (wrap)      coarse_o <= coarse_o + 1'b1;
    end

    // R3
    sync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_rise |=> (coarse_o == '0));

    // R2
    wrap_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !sync_rise) |=> (coarse_o == COARSE_W'($past(coarse_o) + 1'b1)));
endmodule

// File: rtl/ts_channel.sv
// Module ts_channel
// One measuring channel. It latches coarse and phase when the gate opens, counts
// while the gate is open, and holds the word until the valid/ready handshake.
// Assumes: gate_lvl_i is synchronized; gate edges that arrive while a word is held are dropped.
module ts_channel
    import ts_pkg::*;
#(
    parameter int CH_ID    = 0,
    parameter int CH_W     = 2,
    parameter int COARSE_W = 5,
    parameter int PHASE_W  = 4,
    parameter int FINE_W   = 12,
    localparam int WORD_W  = CH_W + COARSE_W + PHASE_W + FINE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                gate_lvl_i,
    input  logic [COARSE_W-1:0] coarse_i,
    input  logic [PHASE_W-1:0]  phase_i,
    input  logic                ready_i,
    output logic                valid_o,
    output logic [WORD_W-1:0]   word_o
);
    localparam logic [FINE_W-1:0] FINE_MAX = '1;
    localparam logic [CH_W-1:0]   ID_VAL   = CH_W'(CH_ID);

    ch_state_t           state_q;
    logic                gate_q;
    logic                rise;
    logic                fall;
    logic [COARSE_W-1:0] coarse_q;
    logic [PHASE_W-1:0]  phase_q;
    logic [FINE_W-1:0]   fine_q;

    assign rise = gate_lvl_i & ~gate_q;
    assign fall = ~gate_lvl_i & gate_q;

    // Keep the previous gate level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= gate_lvl_i;
    end

    // Channel sequencing, field capture and the saturating fine count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CH_IDLE;
            coarse_q <= '0;
            phase_q  <= '0;
            fine_q   <= '0;
        end else begin
            case (state_q)
                CH_IDLE: if (rise) begin
                    coarse_q <= coarse_i;
                    phase_q  <= phase_i;
                    fine_q   <= FINE_W'(1);
                    state_q  <= CH_OPEN;
                end
                CH_OPEN: begin
                    if (fall)                 state_q <= CH_HOLD;
                    else if (fine_q != FINE_MAX) fine_q <= fine_q + 1'b1;
                end
                CH_HOLD: if (ready_i) state_q <= CH_IDLE;
                default: state_q <= CH_IDLE;
            endcase
        end
    end

    assign valid_o = (state_q == CH_HOLD);
    assign word_o  = {ID_VAL, coarse_q, phase_q, fine_q};

    // R8
    hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(word_o)));

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_o) |-> $past(ready_i));

    // R6
    fine_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OPEN && fine_q == FINE_MAX) |=> (fine_q == FINE_MAX));

    // R10
    coarse_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_OPEN) |=> $stable(coarse_q));
endmodule

// File: rtl/hit_stamp_ctrl.sv
// Module hit_stamp_ctrl
// Top level: synchronizes the sync marker and the gates, runs the shared coarse
// counter, and holds one timestamp channel per gate.
// Assumes: all logic runs on the fast count clock; phase_i is stable at each edge.
module hit_stamp_ctrl #(
    parameter int N_CH        = 4,
    parameter int COARSE_W    = 5,
    parameter int PHASE_W     = 4,
    parameter int FINE_W      = 12,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int WORD_W     = CH_W + COARSE_W + PHASE_W + FINE_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PHASE_W-1:0]     phase_i,
    input  logic                   sync_i,
    input  logic [N_CH-1:0]        gate_i,
    input  logic [N_CH-1:0]        ready_i,
    output logic [N_CH-1:0]        valid_o,
    output logic [N_CH*WORD_W-1:0] stamp_o
);
    logic                sync_lvl;
    logic [N_CH-1:0]     gate_lvl;
    logic [COARSE_W-1:0] coarse;

    ts_sync #(.STAGES(SYNC_STAGES)) u_sync_mark (
        .clk(clk), .rst_n(rst_n), .d_i(sync_i), .q_o(sync_lvl)
    );

    ts_coarse #(.COARSE_W(COARSE_W), .PHASE_W(PHASE_W)) u_coarse (
        .clk(clk), .rst_n(rst_n), .sync_lvl_i(sync_lvl),
        .phase_i(phase_i), .coarse_o(coarse)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        ts_sync #(.STAGES(SYNC_STAGES)) u_gate_sync (
            .clk(clk), .rst_n(rst_n), .d_i(gate_i[g]), .q_o(gate_lvl[g])
        );

        ts_channel #(
            .CH_ID(g), .CH_W(CH_W), .COARSE_W(COARSE_W),
            .PHASE_W(PHASE_W), .FINE_W(FINE_W)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .gate_lvl_i(gate_lvl[g]),
            .coarse_i(coarse), .phase_i(phase_i), .ready_i(ready_i[g]),
            .valid_o(valid_o[g]), .word_o(stamp_o[g*WORD_W +: WORD_W])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (valid_o == '0));
endmodule

// File: tb/hit_stamp_ctrl_tb_top.sv
module hit_stamp_ctrl_tb_top;
    localparam int N_CH   = 4;
    localparam int CW     = 5;
    localparam int PW     = 4;
    localparam int FW     = 8;
    localparam int CHW    = 2;
    localparam int WW     = CHW + CW + PW + FW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [PW-1:0]     phase = '0;
    logic              sync = 1'b0;
    logic [N_CH-1:0]   gate = '0;
    logic [N_CH-1:0]   ready = '0;
    logic [N_CH-1:0]   valid;
    logic [N_CH*WW-1:0] stamp;

    int checks = 0;
    int errors = 0;
    int exp_coarse = 0;

    always #10 clk = ~clk;

    hit_stamp_ctrl #(.N_CH(N_CH), .COARSE_W(CW), .PHASE_W(PW), .FINE_W(FW),
                     .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .sync_i(sync),
        .gate_i(gate), .ready_i(ready), .valid_o(valid), .stamp_o(stamp)
    );

    function automatic logic [WW-1:0] mk(int ch, int co, int ph, int fi);
        return {CHW'(ch), CW'(co), PW'(ph), FW'(fi)};
    endfunction

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wrap_phase();
        @(negedge clk) phase = '1;
        @(negedge clk) phase = '0;
        exp_coarse = (exp_coarse + 1) % 32;
    endtask

    task automatic accept(int ch);
        @(negedge clk) ready[ch] = 1'b1;
        @(negedge clk) ready[ch] = 1'b0;
        chk("R9 valid drops on accept", valid[ch], 0);
    endtask

    // Opens gate ch for n sampled cycles and checks the word and its timing
    task automatic hit(int ch, int n, int ph, int exp_fine, string req);
        @(negedge clk) begin phase = PW'(ph); gate[ch] = 1'b1; end
        repeat (n) @(negedge clk);
        gate[ch] = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 valid not on second edge", valid[ch], 0);
        @(negedge clk);
        chk("R8 valid on third edge", valid[ch], 1);
        chk(req, stamp[ch*WW +: WW], mk(ch, exp_coarse, ph, exp_fine));
    endtask

    task automatic test_reset();
        chk("R1 valid low after reset", valid, 0);
        hit(0, 4, 3, 4, "R1 coarse zero after reset");
        accept(0);
    endtask

    task automatic test_basic();
        hit(0, 20, 9, 20, "R4 R5 R7 basic word");
        repeat (5) @(negedge clk);
        chk("R8 valid held", valid[0], 1);
        chk("R8 word held", stamp[0 +: WW], mk(0, exp_coarse, 9, 20));
        accept(0);
    endtask

    task automatic test_coarse();
        repeat (3) wrap_phase();
        hit(1, 7, 5, 7, "R2 coarse after three wraps");
        accept(1);
        repeat (29) wrap_phase();
        hit(1, 2, 4, 2, "R2 coarse wraps to zero");
        accept(1);
    endtask

    task automatic test_sync();
        repeat (2) wrap_phase();
        // sync edge and phase wrap land on the same clock edge
        @(negedge clk) sync = 1'b1;
        @(negedge clk) begin sync = 1'b0; phase = '1; end
        @(negedge clk) phase = '0;
        exp_coarse = 0;
        repeat (3) @(negedge clk);
        hit(3, 6, 11, 6, "R3 sync clears, wins over wrap");
        accept(3);
    endtask

    task automatic test_sync_open();
        repeat (4) wrap_phase();
        @(negedge clk) begin phase = 4'd7; gate[2] = 1'b1; end
        repeat (10) @(negedge clk);
        sync = 1'b1;
        @(negedge clk) sync = 1'b0;
        repeat (19) @(negedge clk);
        gate[2] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 valid after open sync", valid[2], 1);
        chk("R10 coarse kept", stamp[2*WW +: WW], mk(2, 4, 7, 30));
        exp_coarse = 0;
        accept(2);
        hit(2, 3, 7, 3, "R3 next hit after sync");
        accept(2);
    endtask

    task automatic test_sat();
        hit(0, 300, 6, 255, "R6 fine saturates");
        accept(0);
    endtask

    task automatic test_rearm();
        hit(1, 5, 2, 5, "R9 first word");
        @(negedge clk) gate[1] = 1'b1;
        repeat (4) @(negedge clk);
        gate[1] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 word unchanged while held", stamp[WW +: WW], mk(1, exp_coarse, 2, 5));
        accept(1);
        repeat (10) @(negedge clk);
        chk("R9 no word after accept", valid[1], 0);
    endtask

    task automatic test_multi();
        @(negedge clk) begin phase = 4'd6; gate[0] = 1'b1; gate[2] = 1'b1; end
        repeat (11) @(negedge clk);
        gate[0] = 1'b0;
        repeat (6) @(negedge clk);
        gate[2] = 1'b0;
        repeat (3) @(negedge clk);
        chk("R11 both valid", valid, 4'b0101);
        chk("R11 R7 ch0 word", stamp[0 +: WW], mk(0, exp_coarse, 6, 11));
        chk("R11 R7 ch2 word", stamp[2*WW +: WW], mk(2, exp_coarse, 6, 17));
        accept(0);
        chk("R11 ch2 still valid", valid[2], 1);
        accept(2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_coarse();
        test_sync();
        test_sync_open();
        test_sat();
        test_rearm();
        test_multi();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule